// File: doc/BRIEF.md
# Four-Phase Fetch/Execute Sequencer

This block sits at the front of a small 14-bit-instruction controller core. It splits the input clock into four rotating phase strobes, Q1 to Q4, and one full rotation is one instruction cycle. It runs a two-stage pipeline on that rotation. While one word is fetched from program memory, the word fetched in the previous cycle executes. Non-branch instructions therefore finish at a rate of one per cycle.

Each instruction cycle runs in a fixed order:
- At the end of Q1, the fetch address moves to the program counter.
- At the end of Q4, the word read from program memory is captured.
- At the end of the following Q1, that word enters the instruction register.
- In the execute cycle, the operand-read strobe fires in Q2 and the destination-write strobe fires in Q4.

The execute stage can request a branch. The request and its target are sampled at the end of Q4. At the next Q1 the target becomes the fetch address, and the word already fetched is thrown away. The cycle after a branch therefore executes nothing, so a taken branch costs two cycles.

Top module: `quad_phase_pipe`

## Requirements
- R1: `phase` is one-hot, with bit 0 = Q1, bit 1 = Q2, bit 2 = Q3 and bit 3 = Q4. It moves Q1→Q2→Q3→Q4→Q1 on every clock, and the first clock after reset is Q1.
- R2: `clk_out` is 1 during Q1 and Q2, and 0 during Q3 and Q4.
- R3: `pm_addr` takes the next program-counter value at the end of Q1 and advances by one per cycle. The counter is 13 bits wide and wraps from 8191 to 0.
- R4: The word on `pm_rdata` at the end of Q4 appears on `ex_insn`, with `ex_valid` high, after the end of the next Q1.
- R5: `rd_stb` is high only in Q2 and `wr_stb` only in Q4, and each only while `ex_valid` is high.
- R6: A `br_req` that is high at the end of Q4 while `ex_valid` is high has three effects. In the next cycle `pm_addr` equals `br_target` and `ex_valid` is low (flush). In the cycle after that, the word at the target executes.
- R7: `br_req` is ignored during a flush cycle (`ex_valid` low) and in phases other than Q4.
- R8: Reset has four effects. It puts the phase at Q1 and `pm_addr` at 0. It drops `ex_valid`, so the first cycle is a flush. The first executed word is the one at address 0.
- R9: `pm_addr` and `ex_insn` change only at the end of Q1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pm_addr | output | 13 | Program-memory read address |
| pm_rdata | input | 14 | Program-memory read data for `pm_addr` |
| br_req | input | 1 | Branch request from the execute stage |
| br_target | input | 13 | Branch target address |
| phase | output | 4 | One-hot phase strobes Q1..Q4 |
| clk_out | output | 1 | Clock divided by four, high in Q1–Q2 |
| ex_insn | output | 14 | Instruction register contents |
| ex_valid | output | 1 | Instruction register holds a real instruction |
| rd_stb | output | 1 | Operand-read strobe |
| wr_stb | output | 1 | Destination-write strobe |

## Verification
The assertions check the timing rules on every cycle:
- the phase rotation and its one-hot form;
- the divided clock;
- strobe placement;
- when the fetch address and instruction register are allowed to change;
- the plus-one address step;
- the flush and target load after a taken branch.

Which word ends up in the instruction register depends on the memory contents over several cycles. That, together with the ignored requests in flush cycles and the address wrap, is shown only by the bench's scenarios against its reference model.

// File: rtl/qpp_pkg.sv
package qpp_pkg;
  typedef enum logic [1:0] {PH_Q1 = 2'd0, PH_Q2 = 2'd1, PH_Q3 = 2'd2, PH_Q4 = 2'd3} phase_e;

  function automatic phase_e next_phase(input phase_e p);
    return phase_e'(p + 2'd1);
  endfunction

  function automatic logic [3:0] phase_onehot(input phase_e p);
    return 4'b0001 << p;
  endfunction

  function automatic logic phase_clk_high(input phase_e p);
    return (p == PH_Q1) || (p == PH_Q2);
  endfunction
endpackage

// File: rtl/qpp_phase_gen.sv
module qpp_phase_gen
  import qpp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  output logic [3:0] phase,
  output logic       clk_out,
  output logic       is_q1,
  output logic       is_q2,
  output logic       is_q4
);
  phase_e ph;

  always_ff @(posedge clk) begin
    if (!rst_n) ph <= PH_Q1;
    else        ph <= next_phase(ph);
  end

  assign phase   = phase_onehot(ph);
  assign clk_out = phase_clk_high(ph);
  assign is_q1   = (ph == PH_Q1);
  assign is_q2   = (ph == PH_Q2);
  assign is_q4   = (ph == PH_Q4);
endmodule

// File: rtl/qpp_pc_unit.sv
module qpp_pc_unit #(
  parameter int PC_W = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            is_q1,
  input  logic            br_take,
  input  logic [PC_W-1:0] br_tgt,
  output logic [PC_W-1:0] pm_addr
);
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] fetch_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q    <= '0;
      fetch_q <= '0;
    end else if (is_q1) begin
      if (br_take) begin
        fetch_q <= br_tgt;
        pc_q    <= br_tgt + PC_W'(1);
      end else begin
        fetch_q <= pc_q;
        pc_q    <= pc_q + PC_W'(1);
      end
    end
  end

  assign pm_addr = fetch_q;
endmodule

// File: rtl/qpp_fetch_exec.sv
module qpp_fetch_exec #(
  parameter int PC_W   = 13,
  parameter int INSN_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_q1,
  input  logic              is_q2,
  input  logic              is_q4,
  input  logic [INSN_W-1:0] pm_rdata,
  input  logic              br_req,
  input  logic [PC_W-1:0]   br_target,
  output logic [INSN_W-1:0] ex_insn,
  output logic              ex_valid,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic              br_take,
  output logic [PC_W-1:0]   br_tgt_q
);
  logic [INSN_W-1:0] fbuf_q;
  logic              fbuf_v;
  logic              br_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fbuf_q   <= '0;
      fbuf_v   <= 1'b0;
      ex_insn  <= '0;
      ex_valid <= 1'b0;
      br_pend  <= 1'b0;
      br_tgt_q <= '0;
    end else begin
      if (is_q4) begin
        fbuf_q   <= pm_rdata;
        fbuf_v   <= 1'b1;
        br_pend  <= br_req & ex_valid;
        br_tgt_q <= br_target;
      end
      if (is_q1) begin
        ex_insn  <= fbuf_q;
        ex_valid <= fbuf_v & ~br_pend;
        br_pend  <= 1'b0;
      end
    end
  end

  assign br_take = is_q1 & br_pend;
  assign rd_stb  = is_q2 & ex_valid;
  assign wr_stb  = is_q4 & ex_valid;
endmodule

// File: rtl/quad_phase_pipe.sv
module quad_phase_pipe #(
  parameter int PC_W   = 13,
  parameter int INSN_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [PC_W-1:0]   pm_addr,
  input  logic [INSN_W-1:0] pm_rdata,
  input  logic              br_req,
  input  logic [PC_W-1:0]   br_target,
  output logic [3:0]        phase,
  output logic              clk_out,
  output logic [INSN_W-1:0] ex_insn,
  output logic              ex_valid,
  output logic              rd_stb,
  output logic              wr_stb
);
  logic            is_q1, is_q2, is_q4;
  logic            br_take;
  logic [PC_W-1:0] br_tgt_q;

  qpp_phase_gen u_phase (
    .clk(clk), .rst_n(rst_n), .phase(phase), .clk_out(clk_out),
    .is_q1(is_q1), .is_q2(is_q2), .is_q4(is_q4)
  );

  qpp_pc_unit #(.PC_W(PC_W)) u_pc (
    .clk(clk), .rst_n(rst_n), .is_q1(is_q1), .br_take(br_take),
    .br_tgt(br_tgt_q), .pm_addr(pm_addr)
  );

  qpp_fetch_exec #(.PC_W(PC_W), .INSN_W(INSN_W)) u_fx (
    .clk(clk), .rst_n(rst_n), .is_q1(is_q1), .is_q2(is_q2), .is_q4(is_q4),
    .pm_rdata(pm_rdata), .br_req(br_req), .br_target(br_target),
    .ex_insn(ex_insn), .ex_valid(ex_valid), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .br_take(br_take), .br_tgt_q(br_tgt_q)
  );
endmodule

// File: rtl/qpp_checker.sv
module qpp_checker #(
  parameter int PC_W   = 13,
  parameter int INSN_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        phase,
  input logic              clk_out,
  input logic [PC_W-1:0]   pm_addr,
  input logic [INSN_W-1:0] ex_insn,
  input logic              ex_valid,
  input logic              rd_stb,
  input logic              wr_stb,
  input logic              br_take,
  input logic [PC_W-1:0]   br_tgt_q
);
  logic warm;
  always_ff @(posedge clk) begin
    if (!rst_n)        warm <= 1'b0;
    else if (phase[3]) warm <= 1'b1;
  end

  // R1
  onehot_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(phase) == 1);
  // R1
  phase_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warm |=> phase == {$past(phase[2:0]), $past(phase[3])});
  // R2
  clk_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_out == (phase[0] | phase[1]));
  // R5
  rd_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> (phase[1] && ex_valid));
  // R5
  wr_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (phase[3] && ex_valid));
  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !phase[0] |=> $stable(pm_addr));
  // R9
  insn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !phase[0] |=> $stable(ex_insn));
  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && phase[0] && !br_take) |=> pm_addr == $past(pm_addr) + PC_W'(1));
  // R6
  branch_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_take |=> (!ex_valid && pm_addr == $past(br_tgt_q)));
endmodule

bind quad_phase_pipe qpp_checker #(.PC_W(PC_W), .INSN_W(INSN_W)) i_qpp_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase), .clk_out(clk_out),
  .pm_addr(pm_addr), .ex_insn(ex_insn), .ex_valid(ex_valid),
  .rd_stb(rd_stb), .wr_stb(wr_stb), .br_take(br_take), .br_tgt_q(br_tgt_q)
);

// File: tb/test_quad_phase_pipe.sv
module test_quad_phase_pipe;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] pm_addr;
  logic [13:0] pm_rdata;
  logic        br_req = 1'b0;
  logic [12:0] br_target = '0;
  logic [3:0]  phase;
  logic        clk_out;
  logic [13:0] ex_insn;
  logic        ex_valid, rd_stb, wr_stb;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  function automatic logic [13:0] word_at(input int a);
    return 14'(((a * 29 + 3) ^ (a >> 3)) & 16'h3fff);
  endfunction

  assign pm_rdata = word_at(int'(pm_addr));

  quad_phase_pipe i_quad_phase_pipe (
    .clk(clk), .rst_n(rst_n), .pm_addr(pm_addr), .pm_rdata(pm_rdata),
    .br_req(br_req), .br_target(br_target), .phase(phase), .clk_out(clk_out),
    .ex_insn(ex_insn), .ex_valid(ex_valid), .rd_stb(rd_stb), .wr_stb(wr_stb)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: state after each rising edge
  int m_ph, m_next_pc, m_fetch, m_ir, m_tgt;
  bit m_iv, m_pend;
  int fetched[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_next_pc = 0; m_fetch = 0; m_ir = 0; m_iv = 0;
      m_pend = 0; m_tgt = 0; fetched.delete();
    end else begin
      if (m_ph == 0) begin
        if (fetched.size() > 0) m_ir = fetched.pop_front();
        if (m_pend) begin
          m_fetch = m_tgt; m_next_pc = (m_tgt + 1) % 8192; m_iv = 0;
        end else begin
          m_iv = (m_ir >= 0) && m_valid_src;
          m_fetch = m_next_pc; m_next_pc = (m_next_pc + 1) % 8192;
        end
        m_pend = 0;
      end else if (m_ph == 3) begin
        fetched.push_back(int'(word_at(m_fetch)));
        m_pend = br_req && m_iv;
        m_tgt  = int'(br_target);
      end
      m_ph = (m_ph + 1) % 4;
    end
  end

  // first fetched word becomes valid once one Q4 has passed
  bit m_valid_src = 0;
  always @(posedge clk) begin
    if (!rst_n) m_valid_src <= 0;
    else if (m_ph == 0) m_valid_src <= 1;
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R1 phase", phase, 4'b0001 << m_ph);
      check("R2 clk_out", clk_out, (m_ph < 2) ? 1 : 0);
      check("R3 pm_addr", pm_addr, m_fetch);
      check("R4 ex_valid", ex_valid, m_iv);
      if (m_iv) check("R4 ex_insn", ex_insn, m_ir);
      check("R5 rd_stb", rd_stb, (m_ph == 1 && m_iv) ? 1 : 0);
      check("R5 wr_stb", wr_stb, (m_ph == 3 && m_iv) ? 1 : 0);
    end
  end

  task automatic branch_at_q4(input logic [12:0] t);
    @(negedge clk);
    while (phase != 4'b1000) @(negedge clk);
    br_req = 1'b1; br_target = t;
    @(negedge clk);
    br_req = 1'b0; br_target = 13'h0aaa;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset phase", phase, 4'b0001);
    check("R8 reset pm_addr", pm_addr, 0);
    check("R8 reset ex_valid", ex_valid, 0);
    check("R2 reset clk_out", clk_out, 1);
    rst_n = 1'b1;
    // br_req held outside Q4 is ignored (R7)
    br_req = 1'b1; br_target = 13'h0777;
    repeat (3) @(negedge clk);
    br_req = 1'b0;
    check("R8 first cycle flush", ex_valid, 0);
    while (!ex_valid) @(negedge clk);
    check("R8 first word from 0", ex_insn, word_at(0));
    check("R7 no branch outside Q4", pm_addr, 1);
    repeat (20) @(negedge clk);
    begin
      logic [12:0] a2;
      while (phase != 4'b0010) @(negedge clk);
      a2 = pm_addr;
      @(negedge clk); check("R9 hold Q3", pm_addr, a2);
      @(negedge clk); check("R9 hold Q4", pm_addr, a2);
    end
    branch_at_q4(13'h0123);
    @(negedge clk);
    check("R6 target fetched", pm_addr, 13'h0123);
    check("R6 flush cycle", ex_valid, 0);
    branch_at_q4(13'h0555);          // flush cycle: R7 request ignored
    @(negedge clk);
    check("R7 ignored in flush", pm_addr, 13'h0124);
    check("R6 target executes", ex_valid, 1);
    check("R6 target word", ex_insn, word_at(13'h0123));
    branch_at_q4(13'h1fff);
    @(negedge clk);
    check("R3 top address", pm_addr, 13'h1fff);
    repeat (4) @(negedge clk);
    check("R3 wrap to zero", pm_addr, 0);
    check("R3 top word executes", ex_insn, word_at(13'h1fff));
    repeat (12) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule